// File: doc/BRIEF.md
# Reconfigurable Entry Matcher

This block decides whether one stored table entry satisfies a search key. Many copies sit side by side across a memory row, one per entry slot, and each gets the same search key and the same configuration. Each copy reports a hit flag and carries the entry's payload to its output. The logic that picks one winner among several hitting entries sits outside this block.

The configuration is set at run time and is shared by all copies. It picks which key bit positions take part in the comparison. It also picks, for each position, whether the stored mask bit may turn that position into a don't-care. A separate enable adds an unsigned inclusive bounds check on a second field of the key. All of these work on one fixed record layout.

The record is packed from the least significant bit upward as follows:
- `KEY_W` value bits
- `KEY_W` mask bits
- `RNG_W` lower-bound bits
- `RNG_W` upper-bound bits
- `DATA_W` payload bits
- one valid bit at the most significant position

The search key carries the compared bits in `[KEY_W-1:0]` and the bounded field in `[KEY_W+RNG_W-1:KEY_W]`. With the default `OUT_REG=1`, the result appears one clock after the inputs are presented.

Top module: `entry_matcher`

## Requirements
- R1: When the record's valid bit (MSB) is 0, the hit flag is 0 and the payload output is 0, in every configuration.
- R2: A key position whose select bit is 0 never causes a miss, whatever its stored value, mask and key bit are.
- R3: A selected position whose ternary-mode bit is 0 hits only when the stored value bit equals the key bit; the stored mask bit at that position has no effect.
- R4: A selected position whose ternary-mode bit is 1 always hits when its stored mask bit is 1, and otherwise hits only when the stored value bit equals the key bit.
- R5: Binary and ternary behaviour apply at the same time to different positions, as set by the per-position ternary-mode mask.
- R6: With the range enable at 1, the bounded key field hits only when lower <= field <= upper, compared unsigned with both bounds included. With the range enable at 0, the field and the bounds have no effect.
- R7: The overall hit is the AND of the bitwise-compare result, the range result and the valid bit.
- R8: On a hit, the payload output equals the record's payload field; on a miss it is 0.
- R9: With OUT_REG=1, the outputs reflect the inputs sampled at the previous rising clock edge and stay unchanged between edges.
- R10: While rst_n is low at a clock edge, the registered hit flag and payload are cleared to 0.
- R11: With every position selected, every position binary and the range enable at 0, a valid entry hits exactly when the stored value equals the key's compared bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| srch_key | input | KEY_W+RNG_W | Search key: compared bits low, bounded field high |
| rec | input | 2*KEY_W+2*RNG_W+DATA_W+1 | Raw stored record slice |
| cfg_sel | input | KEY_W | 1 = position takes part in the comparison |
| cfg_tern | input | KEY_W | 1 = position honours the stored mask bit |
| cfg_rng_en | input | 1 | 1 = apply the bounds check |
| hit_o | output | 1 | Entry hit flag |
| data_o | output | DATA_W | Payload on hit, else 0 |

## Verification
Exact-equality patterns differ from the stored value in a single bit. This shows whether every selected binary position really takes part. Patterns with deselected positions, and patterns with mask bits set under binary and then ternary mode, separate selection, mask honouring and mask ignoring. Half-binary, half-ternary configurations show that the mode is applied per position. Bounded-field values at lower-1, lower, upper and upper+1, each with the bitwise part hitting and then missing, pin down the inclusive unsigned bounds and the AND of the two parts. A long stretch of pseudo-random records and configurations is compared each clock against a behavioural model.

// File: rtl/entry_match_pkg.sv
// Package: default widths and the per-position compare mode shared by
// the entry matcher and its submodules.
package entry_match_pkg;
    localparam int DEF_KEY_W  = 16;
    localparam int DEF_RNG_W  = 8;
    localparam int DEF_DATA_W = 8;

    typedef enum logic {
        POS_BINARY  = 1'b0,
        POS_TERNARY = 1'b1
    } pos_mode_e;
endpackage

// File: rtl/em_bit_cell.sv
// em_bit_cell: decides one key position.
// An unselected position always hits. A ternary position with its stored
// mask bit set always hits. Otherwise the stored value bit must equal the
// key bit. Assumes all inputs are settled, single-bit values.
module em_bit_cell
    import entry_match_pkg::*;
(
    input  logic      sel_i,
    input  pos_mode_e mode_i,
    input  logic      mask_i,
    input  logic      val_i,
    input  logic      key_i,
    output logic      hit_o
);
    // Per-position hit decision.
    always_comb begin
        if (!sel_i)
            hit_o = 1'b1;
        else if (mode_i == POS_TERNARY && mask_i)
            hit_o = 1'b1;
        else
            hit_o = (val_i == key_i);
    end
endmodule

// File: rtl/em_key_part.sv
// em_key_part: bitwise compare of the key bits against the stored value.
// It builds one em_bit_cell per position and ANDs their results.
// Assumes all vectors are KEY_W wide.
module em_key_part
    import entry_match_pkg::*;
#(
    parameter int KEY_W = DEF_KEY_W
) (
    input  logic [KEY_W-1:0] sel_i,
    input  logic [KEY_W-1:0] tern_i,
    input  logic [KEY_W-1:0] mask_i,
    input  logic [KEY_W-1:0] val_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             hit_o
);
    logic [KEY_W-1:0] pos_hit;

    for (genvar g = 0; g < KEY_W; g++) begin : g_pos
        em_bit_cell u_cell (
            .sel_i  (sel_i[g]),
            .mode_i (pos_mode_e'(tern_i[g])),
            .mask_i (mask_i[g]),
            .val_i  (val_i[g]),
            .key_i  (key_i[g]),
            .hit_o  (pos_hit[g])
        );
    end

    // All positions must hit.
    always_comb hit_o = &pos_hit;
endmodule

// File: rtl/em_range_part.sv
// em_range_part: unsigned inclusive bounds check on one key field.
// When the enable is low the check always passes.
// Assumes lower/upper are stored unsigned; lower > upper never passes.
module em_range_part
    import entry_match_pkg::*;
#(
    parameter int RNG_W = DEF_RNG_W
) (
    input  logic             en_i,
    input  logic [RNG_W-1:0] lo_i,
    input  logic [RNG_W-1:0] hi_i,
    input  logic [RNG_W-1:0] fld_i,
    output logic             ok_o
);
    // Bounds decision.
    always_comb ok_o = !en_i || ((fld_i >= lo_i) && (fld_i <= hi_i));
endmodule

// File: rtl/entry_matcher.sv
// entry_matcher: one entry slot of a search row.
// It unpacks the raw record, runs the bitwise and bounds checks, qualifies
// the result with the valid bit and gates the payload onto the output.
// OUT_REG selects a registered output (1) or a purely combinational one (0).
// Assumes the record layout, from the LSB upward: value, mask, lower,
// upper, payload, valid.
module entry_matcher
    import entry_match_pkg::*;
#(
    parameter int KEY_W   = DEF_KEY_W,
    parameter int RNG_W   = DEF_RNG_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter bit OUT_REG = 1'b1,
    localparam int SK_W   = KEY_W + RNG_W,
    localparam int REC_W  = 2*KEY_W + 2*RNG_W + DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SK_W-1:0]   srch_key,
    input  logic [REC_W-1:0]  rec,
    input  logic [KEY_W-1:0]  cfg_sel,
    input  logic [KEY_W-1:0]  cfg_tern,
    input  logic              cfg_rng_en,
    output logic              hit_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int OFS_MASK = KEY_W;
    localparam int OFS_LO   = 2*KEY_W;
    localparam int OFS_HI   = OFS_LO + RNG_W;
    localparam int OFS_DATA = OFS_HI + RNG_W;
    localparam int OFS_VLD  = OFS_DATA + DATA_W;

    logic [KEY_W-1:0]  f_val, f_mask;
    logic [RNG_W-1:0]  f_lo, f_hi;
    logic [DATA_W-1:0] f_data;
    logic              f_vld;
    logic              key_hit, rng_ok, hit_c;
    logic [DATA_W-1:0] data_c;

    // Split the raw record into its fields.
    always_comb begin
        f_val  = rec[KEY_W-1:0];
        f_mask = rec[OFS_MASK +: KEY_W];
        f_lo   = rec[OFS_LO +: RNG_W];
        f_hi   = rec[OFS_HI +: RNG_W];
        f_data = rec[OFS_DATA +: DATA_W];
        f_vld  = rec[OFS_VLD];
    end

    em_key_part #(.KEY_W(KEY_W)) u_key (
        .sel_i  (cfg_sel),
        .tern_i (cfg_tern),
        .mask_i (f_mask),
        .val_i  (f_val),
        .key_i  (srch_key[KEY_W-1:0]),
        .hit_o  (key_hit)
    );

    em_range_part #(.RNG_W(RNG_W)) u_rng (
        .en_i  (cfg_rng_en),
        .lo_i  (f_lo),
        .hi_i  (f_hi),
        .fld_i (srch_key[KEY_W +: RNG_W]),
        .ok_o  (rng_ok)
    );

    // Combine the partial results and gate the payload.
    always_comb begin
        hit_c  = f_vld && key_hit && rng_ok;
        data_c = hit_c ? f_data : '0;
    end

    if (OUT_REG) begin : g_reg
        // Output stage with synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hit_o  <= 1'b0;
                data_o <= '0;
            end else begin
                hit_o  <= hit_c;
                data_o <= data_c;
            end
        end
    end else begin : g_comb
        // Direct combinational outputs.
        always_comb begin
            hit_o  = hit_c;
            data_o = data_c;
        end
    end
endmodule

// File: rtl/entry_matcher_chk.sv
// entry_matcher_chk: port-level properties of entry_matcher.
// Assumes the registered variant (OUT_REG=1); with OUT_REG=0 no property
// is built.
module entry_matcher_chk #(
    parameter int KEY_W   = 16,
    parameter int RNG_W   = 8,
    parameter int DATA_W  = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int SK_W   = KEY_W + RNG_W,
    localparam int REC_W  = 2*KEY_W + 2*RNG_W + DATA_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SK_W-1:0]   srch_key,
    input logic [REC_W-1:0]  rec,
    input logic [KEY_W-1:0]  cfg_sel,
    input logic [KEY_W-1:0]  cfg_tern,
    input logic              cfg_rng_en,
    input logic              hit_o,
    input logic [DATA_W-1:0] data_o
);
    localparam int OFS_LO = 2*KEY_W;
    localparam int OFS_HI = OFS_LO + RNG_W;

    if (OUT_REG) begin : g_props
        assert_invalid_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !rec[REC_W-1] |=> (!hit_o && data_o == '0));

        assert_unsel_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (rec[REC_W-1] && cfg_sel == '0 && !cfg_rng_en) |=> hit_o);

        assert_out_of_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_rng_en && ((srch_key[KEY_W +: RNG_W] < rec[OFS_LO +: RNG_W]) ||
                            (srch_key[KEY_W +: RNG_W] > rec[OFS_HI +: RNG_W])))
            |=> !hit_o);

        assert_miss_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !hit_o |-> data_o == '0);

        assert_exact_equal_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (rec[REC_W-1] && (&cfg_sel) && cfg_tern == '0 && !cfg_rng_en)
            |=> hit_o == ($past(srch_key[KEY_W-1:0]) == $past(rec[KEY_W-1:0])));
    end
endmodule

bind entry_matcher entry_matcher_chk #(
    .KEY_W(KEY_W), .RNG_W(RNG_W), .DATA_W(DATA_W), .OUT_REG(OUT_REG)
) i_chk (
    .clk(clk), .rst_n(rst_n), .srch_key(srch_key), .rec(rec),
    .cfg_sel(cfg_sel), .cfg_tern(cfg_tern), .cfg_rng_en(cfg_rng_en),
    .hit_o(hit_o), .data_o(data_o)
);

// File: tb/test_entry_matcher.sv
// Bench for entry_matcher with a behavioural model compared every clock.
module test_entry_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int KW = 16;
    localparam int RW = 8;
    localparam int DW = 8;
    localparam int SKW = KW + RW;
    localparam int RCW = 2*KW + 2*RW + DW + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [SKW-1:0] srch_key = '0;
    logic [RCW-1:0] rec = '0;
    logic [KW-1:0]  cfg_sel = '0;
    logic [KW-1:0]  cfg_tern = '0;
    logic           cfg_rng_en = 1'b0;
    logic           hit_o;
    logic [DW-1:0]  data_o;

    int total = 0;
    int bad = 0;
    logic          exp_hit = 1'b0;
    logic [DW-1:0] exp_data = '0;

    entry_matcher #(.KEY_W(KW), .RNG_W(RW), .DATA_W(DW), .OUT_REG(1'b1)) i_entry_matcher (
        .clk(clk), .rst_n(rst_n), .srch_key(srch_key), .rec(rec),
        .cfg_sel(cfg_sel), .cfg_tern(cfg_tern), .cfg_rng_en(cfg_rng_en),
        .hit_o(hit_o), .data_o(data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [RCW-1:0] mkrec(input logic v, input logic [DW-1:0] d,
            input logic [RW-1:0] hi, input logic [RW-1:0] lo,
            input logic [KW-1:0] m, input logic [KW-1:0] val);
        return {v, d, hi, lo, m, val};
    endfunction

    // Behavioural reference: walk the positions, then the bounds, then valid.
    task automatic model(output logic h, output logic [DW-1:0] d);
        int fld, lo, hi;
        h = 1'b1;
        for (int i = 0; i < KW; i++) begin
            if (cfg_sel[i] && !(cfg_tern[i] && rec[KW+i]))
                if (rec[i] != srch_key[i]) h = 1'b0;
        end
        fld = int'(srch_key[KW +: RW]);
        lo  = int'(rec[2*KW +: RW]);
        hi  = int'(rec[2*KW+RW +: RW]);
        if (cfg_rng_en && (fld < lo || fld > hi)) h = 1'b0;
        if (!rec[RCW-1]) h = 1'b0;
        d = h ? rec[2*KW+2*RW +: DW] : '0;
    endtask

    task automatic check(input string tag, input logic h, input logic [DW-1:0] d);
        total++;
        if (hit_o !== h || data_o !== d) begin
            bad++;
            $display("FAIL %s: hit=%0b data=%0h expected hit=%0b data=%0h",
                     tag, hit_o, data_o, h, d);
        end
    endtask

    // Drive at a falling edge, confirm the hold, then compare after the edge.
    task automatic step(input string tag, input logic [SKW-1:0] k, input logic [RCW-1:0] r,
                        input logic [KW-1:0] s, input logic [KW-1:0] t, input logic re);
        logic h;
        logic [DW-1:0] d;
        srch_key = k; rec = r; cfg_sel = s; cfg_tern = t; cfg_rng_en = re;
        #1;
        check("R9 hold", exp_hit, exp_data);
        model(h, d);
        @(posedge clk);
        @(negedge clk);
        check(tag, h, d);
        exp_hit = h; exp_data = d;
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [KW-1:0] ones;
        ones = '1;
        rec = mkrec(1'b1, 8'hAA, 8'hFF, 8'h00, '0, '0);
        cfg_sel = ones;
        repeat (3) @(negedge clk);
        check("R10 reset", 1'b0, '0);
        rst_n = 1'b1;

        // R11 exact equality
        step("R11 equal", {8'h00, 16'h1234}, mkrec(1, 8'h5A, 8'hFF, 8'h00, 16'h0000, 16'h1234), ones, '0, 0);
        step("R11 one bit off", {8'h00, 16'h1235}, mkrec(1, 8'h5A, 8'hFF, 8'h00, 16'h0000, 16'h1234), ones, '0, 0);
        step("R11 top bit off", {8'h00, 16'h9234}, mkrec(1, 8'h5A, 8'hFF, 8'h00, 16'h0000, 16'h1234), ones, '0, 0);
        // R1 invalid entry
        step("R1 invalid", {8'h00, 16'h1234}, mkrec(0, 8'h5A, 8'hFF, 8'h00, 16'h0000, 16'h1234), ones, '0, 0);
        step("R1 invalid all dc", {8'h00, 16'hBEEF}, mkrec(0, 8'h77, 8'hFF, 8'h00, 16'hFFFF, 16'h0000), '0, ones, 0);
        // R2 unselected positions
        step("R2 low byte off", {8'h00, 16'h12FF}, mkrec(1, 8'h11, 8'hFF, 8'h00, 16'h0000, 16'h1200), 16'hFF00, '0, 0);
        step("R2 none selected", {8'h00, 16'hFFFF}, mkrec(1, 8'h22, 8'hFF, 8'h00, 16'h0000, 16'h0000), '0, '0, 0);
        // R3 binary ignores mask
        step("R3 mask ignored", {8'h00, 16'h00F0}, mkrec(1, 8'h33, 8'hFF, 8'h00, 16'hFFFF, 16'h0000), ones, '0, 0);
        // R4 ternary
        step("R4 masked dc", {8'h00, 16'h00F0}, mkrec(1, 8'h44, 8'hFF, 8'h00, 16'h00F0, 16'h0000), ones, ones, 0);
        step("R4 unmasked diff", {8'h00, 16'h01F0}, mkrec(1, 8'h44, 8'hFF, 8'h00, 16'h00F0, 16'h0000), ones, ones, 0);
        // R5 mixed: low byte ternary, high byte binary, mask all ones
        step("R5 low dc", {8'h00, 16'hAB3C}, mkrec(1, 8'h55, 8'hFF, 8'h00, 16'hFFFF, 16'hAB00), ones, 16'h00FF, 0);
        step("R5 high binary", {8'h00, 16'hAC3C}, mkrec(1, 8'h55, 8'hFF, 8'h00, 16'hFFFF, 16'hAB00), ones, 16'h00FF, 0);
        // R6 bounds 0x20..0x40 inclusive
        step("R6 lower-1", {8'h1F, 16'h0000}, mkrec(1, 8'h66, 8'h40, 8'h20, '0, '0), ones, '0, 1);
        step("R6 lower", {8'h20, 16'h0000}, mkrec(1, 8'h66, 8'h40, 8'h20, '0, '0), ones, '0, 1);
        step("R6 upper", {8'h40, 16'h0000}, mkrec(1, 8'h66, 8'h40, 8'h20, '0, '0), ones, '0, 1);
        step("R6 upper+1", {8'h41, 16'h0000}, mkrec(1, 8'h66, 8'h40, 8'h20, '0, '0), ones, '0, 1);
        step("R6 unsigned high", {8'hF0, 16'h0000}, mkrec(1, 8'h66, 8'hFF, 8'h80, '0, '0), ones, '0, 1);
        step("R6 disabled", {8'h99, 16'h0000}, mkrec(1, 8'h66, 8'h40, 8'h20, '0, '0), ones, '0, 0);
        // R7 AND of parts
        step("R7 bits ok range bad", {8'h50, 16'h0001}, mkrec(1, 8'h77, 8'h40, 8'h20, '0, 16'h0001), ones, '0, 1);
        step("R7 bits bad range ok", {8'h30, 16'h0002}, mkrec(1, 8'h77, 8'h40, 8'h20, '0, 16'h0001), ones, '0, 1);
        step("R7 both ok", {8'h30, 16'h0001}, mkrec(1, 8'h77, 8'h40, 8'h20, '0, 16'h0001), ones, '0, 1);
        // R8 payload gating
        step("R8 payload on hit", {8'h00, 16'hC0DE}, mkrec(1, 8'hE7, 8'hFF, 8'h00, '0, 16'hC0DE), ones, '0, 0);
        step("R8 payload on miss", {8'h00, 16'hC0DF}, mkrec(1, 8'hE7, 8'hFF, 8'h00, '0, 16'hC0DE), ones, '0, 0);
        // R10 reset in mid-run clears outputs
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10 mid reset", 1'b0, '0);
        exp_hit = 1'b0; exp_data = '0;
        rst_n = 1'b1;
        // R7 mixed random run; narrow fields raise the hit rate
        for (int n = 0; n < 400; n++) begin
            logic [KW-1:0] v, k;
            v = KW'($urandom);
            k = v ^ (KW'($urandom) & KW'($urandom) & KW'($urandom));
            step("R7 random",
                 {RW'($urandom_range(0, 63)), k},
                 mkrec(1'($urandom_range(0, 7) != 0), DW'($urandom), RW'($urandom_range(16, 63)),
                       RW'($urandom_range(0, 31)), KW'($urandom), v),
                 KW'($urandom) | KW'($urandom), KW'($urandom), 1'($urandom));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule